// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block takes received Ethernet frames as a byte stream marked with start-of-frame and end-of-frame flags and stores each accepted frame in an external packet RAM. The RAM is treated as 256-byte pages. The pages from `ring_start` up to, but not including, `ring_stop` form a circular receive area. The block owns a current-page pointer that marks where the next frame begins. The host owns a boundary pointer that marks the oldest page it has not yet consumed. One page is always left empty, so the current pointer never catches up with the boundary.

Every stored frame begins with a 4-byte header in its first page, followed by the frame bytes. The header holds the receive status, the page number that follows the frame, and the total stored length including the header. The host can therefore walk the ring as a linked list.

The block writes frame bytes speculatively as they arrive, and the current pointer moves only when a frame is committed. A frame rejected part way through (by address, length, controller state or ring state) therefore leaves the ring as it was. If the ring lacks room for the next page, the block lowers `in_ready` and holds the frame until the host advances the boundary.

The control is a single state machine:
- IDLE waits for a start-of-frame byte.
- RECV stores the frame bytes.
- DISCARD swallows the rest of a rejected frame.
- PAD fills short frames with zeros.
- HDR writes the four header bytes and commits.

The transitions are:
- IDLE→RECV on an accepted first byte.
- IDLE→DISCARD on a rejected first byte that is not also the last byte.
- RECV→DISCARD on an address miss or an over-length byte.
- RECV→IDLE on a runt end, or on a rejected byte that is also the last.
- RECV→PAD on a short end.
- RECV→HDR on a normal end.
- PAD→HDR once 60 bytes are reached.
- DISCARD→IDLE on the end flag.
- HDR→IDLE after the fourth header byte.

Top module: `rxring_writer`

## Requirements
- R1: Frame byte i is written at offset 4+i of the frame's first page. Bytes continue at offset 0 of each following ring page once a page is full.
- R2: The header sits at offsets 0..3 of the first page. Offset 0 is the status 0x01 (received intact). Offset 1 is the page that follows the frame. Offset 2 is the low byte and offset 3 the high byte of the stored length plus 4. After commit, `curr_page` equals the following page.
- R3: A current or boundary pointer at or above `ring_stop` is treated as `ring_start`. The page after `ring_stop`-1 is `ring_start`, and every write stays inside the ring.
- R4: Free pages are computed from the current pointer c and the boundary b:
  - c>b: (stop−c)+(b−start)−1
  - c<b: b−c−1
  - c=b: 0

  Before writing into its n-th page, a frame needs at least n free pages. Otherwise `in_ready` is low and the frame is held, not dropped, until the boundary advances. No write ever targets the boundary page.
- R5: A frame that starts while `stopped` is high produces no RAM write, no `rx_done` and no pointer change.
- R6: A frame is kept only if its first 6 bytes equal `station_mac` (most significant byte first) or are all 0xFF. Any other frame is dropped without commit.
- R7: A frame of 12 bytes or fewer, or of more than 2048 bytes, is dropped without commit. Lengths of 13 and 2048 are stored.
- R8: A frame shorter than 60 bytes is stored with a length of 60, and the pad bytes are written as 0x00.
- R9: `rx_done` pulses for exactly one cycle, the cycle after the last header byte is written. `rx_irq` pulses with it only when `rx_irq_en` is high.
- R10: A frame is dropped with no RAM write while the ring is invalid. The ring is invalid when stop ≤ start, when start is 0, when stop exceeds 64, or when the current or boundary pointer is below start.
- R11: The four header writes are the last RAM writes of a stored frame, issued at offsets 0, 1, 2, 3 in that order.
- R12: After reset, `curr_page` is 0, and `rx_done`, `rx_irq` and `ram_we` are low.
- R13: A cycle with `curr_load` high sets `curr_page` to `curr_load_val` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| stopped | input | 1 | controller is in the stopped state |
| ring_start | input | 8 | first page of the receive ring |
| ring_stop | input | 8 | page just past the ring |
| host_bnry | input | 8 | host boundary pointer |
| curr_load | input | 1 | load the current-page pointer |
| curr_load_val | input | 8 | value for the current-page pointer |
| station_mac | input | 48 | station address, first byte in bits 47:40 |
| rx_irq_en | input | 1 | receive interrupt enable |
| in_valid | input | 1 | input byte valid |
| in_sof | input | 1 | first byte of a frame |
| in_eof | input | 1 | last byte of a frame |
| in_data | input | 8 | frame byte |
| in_ready | output | 1 | block accepts the byte |
| ram_we | output | 1 | packet RAM write enable |
| ram_addr | output | 14 | packet RAM byte address {page, offset} |
| ram_wdata | output | 8 | packet RAM write data |
| curr_page | output | 8 | current-page pointer |
| rx_done | output | 1 | frame committed pulse |
| rx_irq | output | 1 | receive interrupt pulse |

## Verification
The bench aims at the page edges. A 252-byte frame ends exactly at a page end and a 253-byte frame spills into a second page. A design that advanced the page too early would link the header to a page too far ahead, and one that advanced it too late would overwrite the header page. The length limits 12/13 and 2048/2049 and the 59/60 pad edge are probed, because an off-by-one there either commits a runt or loses a legal frame. A pointer loaded past the ring end, and random traffic that wraps the ring many times, expose a missing wrap, which would write outside the ring. A stall with a single free page shows whether the block would drop the frame or overrun the boundary instead of holding it.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_DISCARD,
        ST_PAD,
        ST_HDR
    } rx_state_e;

    localparam logic [7:0] STATUS_INTACT = 8'h01;
    localparam int         HDR_BYTES     = 4;

endpackage

// File: rtl/rxring_ring_math.sv
module rxring_ring_math #(
    parameter int PAGE_W   = 8,
    parameter int MAX_STOP = 64
) (
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    input  logic [PAGE_W-1:0] curr_pg,
    input  logic [PAGE_W-1:0] bnry_pg,
    output logic              ring_ok,
    output logic [PAGE_W-1:0] curr_eff,
    output logic [PAGE_W-1:0] bnry_eff,
    output logic [PAGE_W-1:0] free_pages
);

    always_comb begin
        ring_ok = (stop_pg > start_pg) && (start_pg != '0) &&
                  (stop_pg <= PAGE_W'(MAX_STOP)) &&
                  (curr_pg >= start_pg) && (bnry_pg >= start_pg);
        curr_eff = (curr_pg >= stop_pg) ? start_pg : curr_pg;
        bnry_eff = (bnry_pg >= stop_pg) ? start_pg : bnry_pg;
        if (curr_eff == bnry_eff)
            free_pages = '0;
        else if (curr_eff > bnry_eff)
            free_pages = (stop_pg - curr_eff) + (bnry_eff - start_pg) - PAGE_W'(1);
        else
            free_pages = bnry_eff - curr_eff - PAGE_W'(1);
    end

endmodule

// File: rtl/rxring_addr_filter.sv
module rxring_addr_filter #(
    parameter int MAC_BYTES = 6,
    localparam int IDX_W    = $clog2(MAC_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   first,
    input  logic                   step,
    input  logic [IDX_W-1:0]       idx,
    input  logic [7:0]             data,
    input  logic [8*MAC_BYTES-1:0] mac,
    output logic                   keep
);

    logic [7:0] mac_b [MAC_BYTES];
    logic       uni_ok, bc_ok, uni_in, bc_in, uni_hit, bc_hit;
    logic [7:0] want;

    for (genvar g = 0; g < MAC_BYTES; g++) begin : g_split
        assign mac_b[g] = mac[8*(MAC_BYTES-g)-1 -: 8];
    end

    always_comb begin
        want = 8'h00;
        for (int k = 0; k < MAC_BYTES; k++)
            if (idx == IDX_W'(k)) want = mac_b[k];
        uni_in  = first ? 1'b1 : uni_ok;
        bc_in   = first ? 1'b1 : bc_ok;
        uni_hit = uni_in && (data == want);
        bc_hit  = bc_in && (data == 8'hFF);
        keep    = uni_hit || bc_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uni_ok <= 1'b0;
            bc_ok  <= 1'b0;
        end else if (step) begin
            uni_ok <= uni_hit;
            bc_ok  <= bc_hit;
        end
    end

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
    import rxring_pkg::*;
#(
    parameter int PAGE_W     = 8,
    parameter int RAM_PAGES  = 64,
    parameter int PAGE_BYTES = 256,
    parameter int MAX_LEN    = 2048,
    parameter int RUNT_MAX   = 12,
    parameter int PAD_LEN    = 60,
    parameter int MAC_BYTES  = 6,
    localparam int PG_IDX_W  = $clog2(RAM_PAGES),
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int ADDR_W    = PG_IDX_W + OFF_W,
    localparam int LEN_W     = $clog2(MAX_LEN + 1) + 1,
    localparam int MIDX_W    = $clog2(MAC_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stopped,
    input  logic [PAGE_W-1:0]      ring_start,
    input  logic [PAGE_W-1:0]      ring_stop,
    input  logic [PAGE_W-1:0]      host_bnry,
    input  logic                   curr_load,
    input  logic [PAGE_W-1:0]      curr_load_val,
    input  logic [8*MAC_BYTES-1:0] station_mac,
    input  logic                   rx_irq_en,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic                   in_eof,
    input  logic [7:0]             in_data,
    output logic                   in_ready,
    output logic                   ram_we,
    output logic [ADDR_W-1:0]      ram_addr,
    output logic [7:0]             ram_wdata,
    output logic [PAGE_W-1:0]      curr_page,
    output logic                   rx_done,
    output logic                   rx_irq
);

    rx_state_e          state_q, state_d;
    logic [PAGE_W-1:0]  curr_q, wr_pg, pg_cnt;
    logic [PG_IDX_W-1:0] first_pg;
    logic [OFF_W:0]     pos;
    logic [LEN_W-1:0]   len_q, new_len;
    logic [1:0]         hdr_idx;
    logic               done_q, irq_q;

    logic               ring_ok, drop_rx, accept, keep, keep_byte, addr_phase;
    logic               crossing, over, store;
    logic [PAGE_W-1:0]  curr_eff, bnry_eff, free_pages, tgt_pg, wr_nxt;
    logic [OFF_W-1:0]   tgt_off;
    logic [15:0]        tot_len;
    logic [MIDX_W-1:0]  f_idx;

    function automatic logic [PAGE_W-1:0] next_pg(input logic [PAGE_W-1:0] p);
        return (p + PAGE_W'(1) >= ring_stop) ? ring_start : p + PAGE_W'(1);
    endfunction

    rxring_ring_math #(.PAGE_W(PAGE_W), .MAX_STOP(RAM_PAGES)) u_math (
        .start_pg(ring_start), .stop_pg(ring_stop), .curr_pg(curr_q), .bnry_pg(host_bnry),
        .ring_ok(ring_ok), .curr_eff(curr_eff), .bnry_eff(bnry_eff), .free_pages(free_pages)
    );

    assign addr_phase = (state_q == ST_IDLE && in_sof) ||
                        (state_q == ST_RECV && len_q < LEN_W'(MAC_BYTES));
    assign f_idx      = (state_q == ST_IDLE) ? '0 : len_q[MIDX_W-1:0];

    rxring_addr_filter #(.MAC_BYTES(MAC_BYTES)) u_filt (
        .clk(clk), .rst_n(rst_n), .first(state_q == ST_IDLE),
        .step(accept && addr_phase), .idx(f_idx), .data(in_data),
        .mac(station_mac), .keep(keep)
    );

    always_comb begin
        drop_rx   = stopped || !ring_ok;
        accept    = in_valid && in_ready;
        keep_byte = addr_phase ? keep : 1'b1;
        new_len   = (state_q == ST_IDLE) ? LEN_W'(1) : len_q + LEN_W'(1);
        over      = new_len > LEN_W'(MAX_LEN);
        crossing  = (state_q == ST_RECV) && (pos == (OFF_W+1)'(PAGE_BYTES));
        wr_nxt    = next_pg(wr_pg);
        tgt_pg    = crossing ? wr_nxt : ((state_q == ST_IDLE) ? curr_eff : wr_pg);
        tgt_off   = crossing ? '0 : ((state_q == ST_IDLE) ? OFF_W'(HDR_BYTES) : pos[OFF_W-1:0]);
        tot_len   = 16'(len_q) + 16'(HDR_BYTES);
        store     = accept && keep_byte && !over &&
                    ((state_q == ST_RECV) || (in_sof && !drop_rx));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && in_sof) begin
                if (drop_rx || !keep) state_d = in_eof ? ST_IDLE : ST_DISCARD;
                else if (in_eof)      state_d = ST_IDLE;
                else                  state_d = ST_RECV;
            end
            ST_RECV: if (accept) begin
                if (!keep_byte || over)               state_d = in_eof ? ST_IDLE : ST_DISCARD;
                else if (in_eof && new_len <= LEN_W'(RUNT_MAX)) state_d = ST_IDLE;
                else if (in_eof && new_len < LEN_W'(PAD_LEN))   state_d = ST_PAD;
                else if (in_eof)                      state_d = ST_HDR;
            end
            ST_DISCARD: if (accept && in_eof) state_d = ST_IDLE;
            ST_PAD:     if (len_q + LEN_W'(1) == LEN_W'(PAD_LEN)) state_d = ST_HDR;
            ST_HDR:     if (hdr_idx == 2'd3) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            curr_q   <= '0;
            first_pg <= '0;
            wr_pg    <= '0;
            pos      <= '0;
            pg_cnt   <= '0;
            len_q    <= '0;
            hdr_idx  <= '0;
            done_q   <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_HDR) && (hdr_idx == 2'd3);
            irq_q   <= (state_q == ST_HDR) && (hdr_idx == 2'd3) && rx_irq_en;
            if (curr_load) curr_q <= curr_load_val;
            if (store && state_q == ST_IDLE) begin
                first_pg <= curr_eff[PG_IDX_W-1:0];
                wr_pg    <= curr_eff;
                pos      <= (OFF_W+1)'(HDR_BYTES + 1);
                pg_cnt   <= PAGE_W'(1);
                len_q    <= LEN_W'(1);
            end else if (store) begin
                len_q <= new_len;
                if (crossing) begin
                    wr_pg  <= wr_nxt;
                    pos    <= (OFF_W+1)'(1);
                    pg_cnt <= pg_cnt + PAGE_W'(1);
                end else begin
                    pos <= pos + (OFF_W+1)'(1);
                end
            end
            if (state_q == ST_PAD) begin
                pos   <= pos + (OFF_W+1)'(1);
                len_q <= len_q + LEN_W'(1);
            end
            if (state_q == ST_HDR) begin
                hdr_idx <= hdr_idx + 2'd1;
                if (hdr_idx == 2'd3) curr_q <= wr_nxt;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = {tgt_pg[PG_IDX_W-1:0], tgt_off};
        ram_wdata = in_data;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = drop_rx || (free_pages != '0);
                ram_we   = store;
            end
            ST_RECV: begin
                in_ready = !crossing || (free_pages > pg_cnt) || (len_q >= LEN_W'(MAX_LEN));
                ram_we   = store;
            end
            ST_DISCARD: in_ready = 1'b1;
            ST_PAD: begin
                ram_we    = 1'b1;
                ram_addr  = {wr_pg[PG_IDX_W-1:0], pos[OFF_W-1:0]};
                ram_wdata = 8'h00;
            end
            ST_HDR: begin
                ram_we   = 1'b1;
                ram_addr = {first_pg, OFF_W'(hdr_idx)};
                case (hdr_idx)
                    2'd0:    ram_wdata = STATUS_INTACT;
                    2'd1:    ram_wdata = 8'(wr_nxt);
                    2'd2:    ram_wdata = tot_len[7:0];
                    default: ram_wdata = tot_len[15:8];
                endcase
            end
            default: ;
        endcase
    end

    assign curr_page = curr_q;
    assign rx_done   = done_q;
    assign rx_irq    = irq_q;

endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk #(
    parameter int PAGE_W   = 8,
    parameter int PG_IDX_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ram_we,
    input logic [PG_IDX_W-1:0] wr_page,
    input logic [PAGE_W-1:0]   ring_start,
    input logic [PAGE_W-1:0]   ring_stop,
    input logic [PAGE_W-1:0]   host_bnry,
    input logic [PAGE_W-1:0]   curr_page,
    input logic                rx_done,
    input logic                rx_irq,
    input logic                rx_irq_en
);

    logic [PAGE_W-1:0] bnry_eff, wpage;
    assign bnry_eff = (host_bnry >= ring_stop) ? ring_start : host_bnry;
    assign wpage    = PAGE_W'(wr_page);

    // R4
    page_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> wpage != bnry_eff);

    // R3
    in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (wpage >= ring_start) && (wpage < ring_stop));

    // R2
    curr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> curr_page != $past(curr_page));

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_done && $past(rx_irq_en));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

endmodule

bind rxring_writer rxring_writer_chk #(.PAGE_W(PAGE_W), .PG_IDX_W(PG_IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .wr_page(ram_addr[ADDR_W-1:OFF_W]),
    .ring_start(ring_start), .ring_stop(ring_stop), .host_bnry(host_bnry),
    .curr_page(curr_page), .rx_done(rx_done), .rx_irq(rx_irq), .rx_irq_en(rx_irq_en)
);

// File: tb/rxring_writer_bench.sv
module rxring_writer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stopped = 1'b0;
    logic [7:0]  ring_start = 8'd1, ring_stop = 8'd16, host_bnry = 8'd1;
    logic        curr_load = 1'b0;
    logic [7:0]  curr_load_val = 8'd0;
    logic [47:0] station_mac = 48'h02_11_22_33_44_55;
    logic        rx_irq_en = 1'b1;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        in_ready, ram_we, rx_done, rx_irq;
    logic [13:0] ram_addr;
    logic [7:0]  ram_wdata, curr_page;

    rxring_writer u_rxring_writer (
        .clk(clk), .rst_n(rst_n), .stopped(stopped), .ring_start(ring_start),
        .ring_stop(ring_stop), .host_bnry(host_bnry), .curr_load(curr_load),
        .curr_load_val(curr_load_val), .station_mac(station_mac), .rx_irq_en(rx_irq_en),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .in_ready(in_ready), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .curr_page(curr_page), .rx_done(rx_done), .rx_irq(rx_irq)
    );

    always #10 clk = ~clk;

    int compared = 0, mismatched = 0;
    logic [7:0] mem [int];
    int wcnt = 0, dcnt = 0, icnt = 0, stalls = 0;
    int wlog [4];
    int dlog [4];
    logic [7:0] fb [0:2099];
    int exp_curr;

    // monitor: one ns before each rising edge
    always begin
        @(negedge clk);
        #9;
        if (ram_we) begin
            mem[int'(ram_addr)] = ram_wdata;
            wcnt++;
            wlog[0] = wlog[1]; wlog[1] = wlog[2]; wlog[2] = wlog[3];
            wlog[3] = int'(ram_addr);
        end
        if (rx_done) begin
            dcnt++;
            dlog = wlog;
        end
        if (rx_irq) icnt++;
        if (in_valid && !in_ready) stalls++;
    end

    task automatic chk(string req, int act, int exp, string what);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int nxtp(int p);
        return (p + 1 >= int'(ring_stop)) ? int'(ring_start) : p + 1;
    endfunction

    function automatic int prevp(int p);
        return (p == int'(ring_start)) ? int'(ring_stop) - 1 : p - 1;
    endfunction

    // kind: 0 station, 1 broadcast, 2 foreign, 3 near miss in last address byte
    task automatic build(int len, int kind);
        for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
        for (int i = 0; i < 6 && i < len; i++) begin
            case (kind)
                0: fb[i] = station_mac[8*(6-i)-1 -: 8];
                1: fb[i] = 8'hFF;
                2: fb[i] = 8'h10 + 8'(i);
                default: fb[i] = (i == 5) ? 8'h56 : station_mac[8*(6-i)-1 -: 8];
            endcase
        end
    endtask

    task automatic send(int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1); in_data = fb[i];
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic run_frame(int len, int kind, bit ok, string req);
        int d0, i0, c0, plen, pg, off, errs, nxt;
        d0 = dcnt; i0 = icnt; c0 = exp_curr;
        build(len, kind);
        send(len);
        repeat (80) @(negedge clk);
        if (!ok) begin
            chk(req, dcnt - d0, 0, "dropped frame committed");
            chk(req, int'(curr_page), c0, "pointer after drop");
            return;
        end
        chk(req, dcnt - d0, 1, "frame commit count");
        plen = (len < 60) ? 60 : len;
        pg = c0; off = 4; errs = 0;
        for (int j = 0; j < plen; j++) begin
            if (off == 256) begin pg = nxtp(pg); off = 0; end
            if (!mem.exists(pg*256 + off) ||
                mem[pg*256 + off] != ((j < len) ? fb[j] : 8'h00)) errs++;
            off++;
        end
        nxt = nxtp(pg);
        // R1 layout, R8 zero padding
        chk((len < 60) ? "R8" : "R1", errs, 0, "payload/pad byte errors");
        chk("R2", int'(mem[c0*256 + 0]), 1, "status byte");
        chk("R2", int'(mem[c0*256 + 1]), nxt, "next page link");
        chk("R2", int'(mem[c0*256 + 2]) + 256*int'(mem[c0*256 + 3]), plen + 4, "length field");
        chk("R2", int'(curr_page), nxt, "current pointer");
        chk("R11", (dlog[0] == c0*256) && (dlog[1] == c0*256+1) &&
                   (dlog[2] == c0*256+2) && (dlog[3] == c0*256+3), 1, "header written last");
        chk("R9", icnt - i0, rx_irq_en ? 1 : 0, "interrupt pulses");
        exp_curr = nxt;
        @(negedge clk);
        host_bnry = 8'(prevp(exp_curr));
    endtask

    initial begin
        #(20 * 190000);
        mismatched++;
        $display("FAIL watchdog all-requirements: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int w0, s0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", int'(curr_page), 0, "reset pointer");
        chk("R12", {rx_done, rx_irq, ram_we}, 0, "reset pulses");
        rst_n = 1'b1;
        @(negedge clk);
        curr_load = 1'b1; curr_load_val = 8'd2;
        @(negedge clk);
        curr_load = 1'b0;
        chk("R13", int'(curr_page), 2, "loaded pointer");
        exp_curr = 2;

        run_frame(60, 0, 1, "R1");
        run_frame(13, 1, 1, "R8");
        run_frame(12, 0, 0, "R7");
        run_frame(59, 0, 1, "R8");
        run_frame(252, 0, 1, "R1");
        run_frame(253, 0, 1, "R1");
        run_frame(2048, 0, 1, "R7");
        run_frame(2049, 0, 0, "R7");
        run_frame(100, 2, 0, "R6");
        run_frame(100, 3, 0, "R6");
        run_frame(100, 1, 1, "R6");

        // R5 stopped controller
        stopped = 1'b1; w0 = wcnt;
        run_frame(80, 0, 0, "R5");
        chk("R5", wcnt - w0, 0, "writes while stopped");
        stopped = 1'b0;

        // R10 invalid ring (start page 0)
        ring_start = 8'd0; w0 = wcnt;
        run_frame(80, 0, 0, "R10");
        chk("R10", wcnt - w0, 0, "writes with invalid ring");
        ring_start = 8'd1;

        // R9 interrupt disabled
        rx_irq_en = 1'b0;
        run_frame(70, 0, 1, "R9");
        rx_irq_en = 1'b1;

        // R3 pointer beyond stop treated as start
        @(negedge clk);
        curr_load = 1'b1; curr_load_val = 8'd20;
        @(negedge clk);
        curr_load = 1'b0;
        host_bnry = 8'(int'(ring_stop) - 1);
        exp_curr = int'(ring_start);
        run_frame(300, 0, 1, "R3");

        // R4 backpressure with a single free page
        host_bnry = 8'(nxtp(nxtp(exp_curr)));
        s0 = stalls;
        fork
            run_frame(600, 0, 1, "R4");
            begin
                wait (stalls > s0);
                repeat (40) @(negedge clk);
                host_bnry = 8'(prevp(exp_curr));
            end
        join
        chk("R4", (stalls > s0) ? 1 : 0, 1, "stall observed");

        // random traffic, wraps the ring repeatedly (R3)
        for (int n = 0; n < 25; n++) begin
            int len, kind;
            len  = 13 + int'($urandom % 1400);
            kind = int'($urandom % 5);
            if (kind > 2) kind = 0;
            run_frame(len, kind, kind != 2, "R3");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule